// File: doc/BRIEF.md
# Lane-Gated Register Write Front End

This block accepts register writes from a 32-bit bus master and applies them to a small bank of 32-bit registers. The bus carries no byte strobes. The byte lanes a store may touch are set instead by a lane-mask field in a separate control register. Software writes the mask first and then issues the data store. Only the enabled lanes of the target register take the new data. Lanes whose enable is clear keep their old bytes.

The data bus is lane-aligned. Byte lane k of a register is always carried on `wr_data[8k+7:8k]`. Software builds the mask from the store width and the byte offset m, which is address bits [1:0]:

- a full word uses all four lanes;
- a halfword uses lanes m and m+1;
- a single byte uses lane m.

Word index `NUM_REGS` selects the control register. Indices 0 to `NUM_REGS-1` select the bank. Any higher index selects nothing. Readback goes through a separate read address, either combinationally or after one register stage.

Top module: `lane_gated_regfile`

## Requirements
- R1: While `rst_n` is low, the lane mask is set to `RESET_MASK` (all four lanes by default, so the control register reads 0x78) and every bank register is cleared to zero.
- R2: A read of the control index returns the lane mask in bits [6:3], with lane 0 at bit 3. Every other bit reads as zero, whatever value was last written.
- R3: A write to the control index loads `wr_data[6:3]` into the lane mask and leaves every bank register unchanged.
- R4: A write to bank index i copies `wr_data[8k+7:8k]` into byte k of register i for each lane k whose mask bit (control bit 3+k) is set.
- R5: During a bank write, byte lanes whose mask bit is clear keep their previous contents, and registers other than the target keep all their contents.
- R6: With an all-zero lane mask, a bank write changes no register.
- R7: The lane mask keeps its value across any number of bank writes and changes only on a control write or reset.
- R8: Writes to a word index above `NUM_REGS` change neither the bank nor the mask, and reads of such an index return zero.
- R9: With `READ_REG`=1, `rd_data` shows the word selected by the `rd_addr` present at the previous rising clock edge. With `READ_REG`=0, it follows `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_addr | input | $clog2(NUM_REGS+1) | Word index of the write target |
| wr_data | input | DATA_W | Lane-aligned write data |
| rd_addr | input | $clog2(NUM_REGS+1) | Word index to read |
| rd_data | output | DATA_W | Readback word |

## Verification
The bench builds the block with `NUM_REGS`=6, which makes the address 3 bits wide. The control register then sits at index 6, and index 7 is an unmapped slot that can be both written and read (R8). The bench builds it with `READ_REG`=1, which exposes the one-cycle read latency. A check samples the output before the new address is clocked in and again after. Every byte offset for byte stores, the even offsets for halfword stores, a zero mask, junk bits around the mask field, and a reset in the middle of the run are all compared against a behavioural model of the byte merge.

// File: rtl/lgr_pkg.sv
package lgr_pkg;
   localparam int unsigned LANE_BITS = 8;

   typedef enum logic [1:0] {
      RSEL_BANK = 2'd0,
      RSEL_CTRL = 2'd1,
      RSEL_NONE = 2'd2
   } rsel_e;

   function automatic int unsigned lanes_of(int unsigned width);
      return width / LANE_BITS;
   endfunction
endpackage

// File: rtl/lgr_addr_decode.sv
module lgr_addr_decode #(
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                ctrl_hit,
   output logic [NUM_REGS-1:0] bank_sel
);
   assign ctrl_hit = (addr == ADDR_W'(NUM_REGS));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign bank_sel[i] = (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/lgr_ctrl_reg.sv
module lgr_ctrl_reg #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_LSB   = 3,
   parameter logic [LANES-1:0] RESET_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LANES-1:0]  field_in,
   output logic [LANES-1:0]  mask,
   output logic [DATA_W-1:0] rd_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= RESET_MASK;
      end else if (we) begin
         mask <= field_in;
      end
   end

   assign rd_word = DATA_W'(mask) << LANE_LSB;
endmodule

// File: rtl/lgr_lane_bank.sv
module lgr_lane_bank
   import lgr_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned LANES    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [NUM_REGS-1:0]        sel,
   input  logic [LANES-1:0]           mask,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] bank_flat
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic                 lane_we;
         logic [LANE_BITS-1:0] lane_q;

         assign lane_we = we & sel[i] & mask[l];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else if (lane_we) begin
               lane_q <= wdata[l*LANE_BITS +: LANE_BITS];
            end
         end

         assign bank_flat[i*DATA_W + l*LANE_BITS +: LANE_BITS] = lane_q;
      end
   end
endmodule

// File: rtl/lane_gated_regfile.sv
module lane_gated_regfile
   import lgr_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_REGS   = 8,
   parameter int unsigned LANE_LSB   = 3,
   parameter logic [3:0]  RESET_MASK = 4'hF,
   parameter bit          READ_REG   = 1'b0,
   localparam int unsigned ADDR_W    = $clog2(NUM_REGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned LANES = lanes_of(DATA_W);

   if (DATA_W % LANE_BITS != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("mask field is four lanes wide; DATA_W must be 32");
   end
   if (LANE_LSB + LANES > DATA_W) begin : g_bad_field
      $error("lane field does not fit in the control word");
   end
   if (NUM_REGS < 1) begin : g_bad_depth
      $error("NUM_REGS must be at least 1");
   end

   logic                       ctrl_hit;
   logic [NUM_REGS-1:0]        bank_sel;
   logic [LANES-1:0]           ctrl_mask;
   logic [DATA_W-1:0]          ctrl_word;
   logic [NUM_REGS*DATA_W-1:0] bank_flat;

   lgr_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_wdec (
      .addr     (wr_addr),
      .ctrl_hit (ctrl_hit),
      .bank_sel (bank_sel)
   );

   lgr_ctrl_reg #(
      .DATA_W     (DATA_W),
      .LANES      (LANES),
      .LANE_LSB   (LANE_LSB),
      .RESET_MASK (RESET_MASK[LANES-1:0])
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_en & ctrl_hit),
      .field_in (wr_data[LANE_LSB +: LANES]),
      .mask     (ctrl_mask),
      .rd_word  (ctrl_word)
   );

   lgr_lane_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .LANES(LANES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_en),
      .sel       (bank_sel),
      .mask      (ctrl_mask),
      .wdata     (wr_data),
      .bank_flat (bank_flat)
   );

   // read path
   rsel_e             rsel;
   logic [DATA_W-1:0] bank_word;
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      if (rd_addr < ADDR_W'(NUM_REGS))       rsel = RSEL_BANK;
      else if (rd_addr == ADDR_W'(NUM_REGS)) rsel = RSEL_CTRL;
      else                                   rsel = RSEL_NONE;
   end

   always_comb begin
      bank_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i)) bank_word = bank_flat[i*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      unique case (rsel)
         RSEL_BANK: rd_next = bank_word;
         RSEL_CTRL: rd_next = ctrl_word;
         default:   rd_next = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_next;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_next;
   end
endmodule

// File: rtl/lane_gated_regfile_chk.sv
module lane_gated_regfile_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_REGS   = 8,
   parameter int unsigned LANE_LSB   = 3,
   parameter logic [3:0]  RESET_MASK = 4'hF,
   parameter int unsigned ADDR_W     = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic [3:0]                 ctrl_mask,
   input logic [NUM_REGS*DATA_W-1:0] bank_flat
);
   logic ctrl_wr;
   logic hole_wr;
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(NUM_REGS));
   assign hole_wr = wr_en && (wr_addr > ADDR_W'(NUM_REGS));

   a_r1_reset_mask: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ctrl_mask == RESET_MASK);

   a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> ctrl_mask == $past(wr_data[LANE_LSB +: 4]));

   a_r3_ctrl_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> $stable(bank_flat));

   a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(ctrl_mask));

   a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctrl_mask == 4'h0) |=> $stable(bank_flat));

   a_r8_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      hole_wr |=> ($stable(bank_flat) && $stable(ctrl_mask)));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      for (genvar l = 0; l < 4; l++) begin : g_lane
         a_r4_lane_take: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(i) && ctrl_mask[l]) |=>
               bank_flat[i*DATA_W + l*8 +: 8] == $past(wr_data[l*8 +: 8]));
         a_r5_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(i) && ctrl_mask[l]) |=>
               $stable(bank_flat[i*DATA_W + l*8 +: 8]));
      end
   end
endmodule

bind lane_gated_regfile lane_gated_regfile_chk #(
   .DATA_W     (DATA_W),
   .NUM_REGS   (NUM_REGS),
   .LANE_LSB   (LANE_LSB),
   .RESET_MASK (RESET_MASK),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .ctrl_mask (ctrl_mask),
   .bank_flat (bank_flat)
);

// File: tb/tb_lane_gated_regfile.sv
`timescale 1ns/1ps
module tb_lane_gated_regfile;
   localparam int NREG = 6;
   localparam int AW   = 3;
   localparam int CTRL = NREG;
   localparam int HOLE = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [31:0] m_bank [NREG];
   logic [3:0]  m_mask;

   always #2.5 clk = ~clk;

   lane_gated_regfile #(.NUM_REGS(NREG), .READ_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [31:0] model_read(int idx);
      if (idx < NREG)       return m_bank[idx];
      else if (idx == CTRL) return {25'd0, m_mask, 3'd0};
      else                  return 32'd0;
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NREG; i++) m_bank[i] = '0;
      m_mask = 4'hF;
   endtask

   task automatic do_write(int idx, logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(idx); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < NREG) begin
         for (int l = 0; l < 4; l++)
            if (m_mask[l]) m_bank[idx][l*8 +: 8] = data[l*8 +: 8];
      end else if (idx == CTRL) begin
         m_mask = data[6:3];
      end
   endtask

   task automatic read_check(string tag, int idx);
      @(negedge clk);
      rd_addr = AW'(idx);
      @(negedge clk);
      check(tag, rd_data, model_read(idx));
   endtask

   task automatic sweep(string tag);
      for (int i = 0; i < 8; i++) read_check(tag, i);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      sweep("R1 reset state");
      check("R1 ctrl reads 0x78", model_read(CTRL), 32'h78);

      // R4: full-word writes, all lanes
      for (int i = 0; i < NREG; i++) do_write(i, 32'h1111_1111 * (i + 1) ^ 32'hA5C3_0F96);
      sweep("R4 full word");

      // R2 / R3: junk around the field
      do_write(CTRL, 32'hFFFF_FFFF);
      read_check("R2 all-ones ctrl", CTRL);
      do_write(CTRL, 32'h0000_00A5);
      read_check("R2 ctrl field only", CTRL);
      check("R2 ctrl 0xA5 reads 0x20", model_read(CTRL), 32'h20);
      sweep("R3 bank untouched by ctrl");

      // R4 / R5: byte stores at every offset
      for (int m = 0; m < 4; m++) begin
         for (int r = 0; r < NREG; r += 2) begin
            do_write(CTRL, 32'((1 << m) << 3));
            d = $urandom;
            do_write(r, d);
            read_check("R4 byte lane", r);
            read_check("R5 neighbour kept", r + 1);
         end
      end
      // halfword stores at even offsets
      for (int m = 0; m < 4; m += 2) begin
         for (int r = 1; r < NREG; r += 2) begin
            do_write(CTRL, 32'((3 << m) << 3));
            do_write(r, $urandom);
            read_check("R5 halfword merge", r);
         end
      end
      sweep("R5 after narrow writes");

      // R6: zero mask
      do_write(CTRL, 32'h0000_0787);
      read_check("R6 ctrl zero", CTRL);
      for (int i = 0; i < NREG; i++) do_write(i, 32'hDEAD_BEEF);
      sweep("R6 zero mask no change");

      // R7: mask persists across several data writes
      do_write(CTRL, 32'h0000_0048);
      do_write(0, 32'h0102_0304);
      do_write(3, 32'hF0E0_D0C0);
      do_write(5, 32'h7777_7777);
      read_check("R7 mask held", CTRL);
      sweep("R7 repeated writes");

      // R8: unmapped slot
      do_write(CTRL, 32'h78);
      do_write(HOLE, 32'h0000_0000);
      sweep("R8 hole write ignored");
      read_check("R8 hole reads zero", HOLE);

      // R9: read latency
      do_write(0, 32'h1234_5678);
      do_write(1, 32'h9ABC_DEF0);
      read_check("R9 first addr", 0);
      @(negedge clk);
      rd_addr = AW'(1);
      #1;
      check("R9 old word before edge", rd_data, 32'h1234_5678);
      @(negedge clk);
      check("R9 new word after edge", rd_data, 32'h9ABC_DEF0);

      // R1: reset mid-run
      do_write(CTRL, 32'h08);
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      sweep("R1 reset mid-run");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule